// File: doc/BRIEF.md
# Differential Clock Output Stop and Power-Down Controller

This block makes the logic-level drive for a set of differential clock output pairs and decides when each pair runs, parks or floats. It runs on one reference clock `clk`. Inside it divides `clk` by two to form a free-running output phase. Each enabled pair sends that phase on its true leg and the inverse on its complement leg. The complement clock rises on every `clk` edge where the true phase falls from high to low. This happens every second cycle, and these edges are the "qualification ticks".

Two asynchronous active-low requests act on the outputs: a stop request and a power-down request. Each request first passes through a two-flop synchronizer. It is then accepted only when it shows the same level on two consecutive qualification ticks. An accepted stop parks every pair marked stoppable at its next suitable transition, and pairs marked free-run keep toggling. An accepted power-down parks every enabled pair at the next high-to-low transition of the complement leg. Each kind of park has its own drive-mode bit. Mode 0 gives a driven-high true leg with the complement leg undriven. Mode 1 leaves both legs undriven and low. Output-enable pins pass through a polarity select that is captured during reset. Register enable bits, stoppable bits and drive modes arrive as plain configuration inputs.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high the output phase is low. Every enabled pair then shows true leg 0 and complement leg 1, with both legs driven.
- R2: Every enabled pair that is not parked toggles its true leg on every `clk` edge, keeps the complement leg at its inverse, and drives both legs.
- R3: A request is acted on only after it holds one level on two consecutive qualification ticks, taken after a two-flop synchronizer. A pulse lasting one `clk` cycle has no effect.
- R4: When a stop is accepted, pairs with `cfg_stoppable_i` bit 1 park. Pairs with the bit at 0 keep toggling.
- R5: A stop-parked pair shows {p,n,p_oe,n_oe} = {1,0,1,0} when `cfg_stop_tri_i` = 0, and {0,0,0,0} when it is 1.
- R6: After the stop request returns high, every stopped pair resumes in the same cycle, 4 to 13 `clk` cycles after the release. A driven leg only ever changes to the level of the free-running phase, so no runt pulse appears.
- R7: When a power-down is accepted, every enabled pair parks, whatever its stoppable bit.
- R8: A power-down-parked pair shows {1,0,1,0} when `cfg_pd_tri_i` = 0, and {0,0,0,0} when it is 1.
- R9: Power-down takes priority over stop. With both accepted, every enabled pair shows the power-down park state.
- R10: A pair is driven only when its `cfg_en_i` bit is 1 and its enable pin is active. A disabled pair shows {0,0,0,0}.
- R11: If the polarity value captured during reset is 0, the enable pins are active high; if it is 1, they are active low. The value on `oe_pol_i` is taken while `rst` is high, and later changes have no effect.
- R12: After the power-down request returns high and is accepted, all pairs go back to running or to their stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; output pairs run at half its rate |
| rst | input | 1 | Synchronous active-high reset; also captures `oe_pol_i` |
| stop_req_n_i | input | 1 | Asynchronous active-low stop request |
| pd_req_n_i | input | 1 | Asynchronous active-low power-down request |
| oe_pin_i | input | NUM_PAIRS | Per-pair enable pins, polarity set by the captured select |
| oe_pol_i | input | 1 | Enable-pin polarity select, sampled during reset |
| cfg_en_i | input | NUM_PAIRS | Per-pair register enable (1 = enabled) |
| cfg_stoppable_i | input | NUM_PAIRS | Per-pair stop behavior (1 = stoppable, 0 = free-run) |
| cfg_stop_tri_i | input | 1 | Stop park mode (0 = true driven high, 1 = both undriven) |
| cfg_pd_tri_i | input | 1 | Power-down park mode (0 = true driven high, 1 = both undriven) |
| out_p_o | output | NUM_PAIRS | True-leg values |
| out_n_o | output | NUM_PAIRS | Complement-leg values |
| out_p_oe_o | output | NUM_PAIRS | True-leg drive enables |
| out_n_oe_o | output | NUM_PAIRS | Complement-leg drive enables |

## Verification
The edge-alignment and park-state properties assume that the stoppable bits and both drive-mode bits stay fixed while a stop or power-down is accepted or pending. They also assume that `oe_pol_i` only matters while reset is held. The stimulus changes configuration only after both requests have been released for at least 16 cycles. It holds each accepted request for 14 cycles before checking. It uses deliberate one-cycle pulses only to probe the qualification rule.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Drive state of one differential pair.
  typedef struct packed {
    logic p;
    logic n;
    logic p_oe;
    logic n_oe;
  } leg_t;

  // Idle level of the active-low request inputs.
  localparam logic REQ_IDLE = 1'b1;

  // Parked state for a given drive mode: 0 keeps true leg driven high.
  function automatic leg_t park_legs(input logic tri_mode);
    leg_t r;
    r.p    = ~tri_mode;
    r.n    = 1'b0;
    r.p_oe = ~tri_mode;
    r.n_oe = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/clkstop_req_qual.sv
// Synchronizes one asynchronous request and accepts a new level only after
// it holds for QUAL_SAMPLES consecutive qualification ticks.
module clkstop_req_qual #(
  parameter int   SYNC_STAGES  = 2,
  parameter int   QUAL_SAMPLES = 2,
  parameter logic IDLE_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req_async,
  output logic level_o
);
  localparam int HW = QUAL_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{IDLE_LVL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= {HW{IDLE_LVL}};
      level_o <= IDLE_LVL;
    end else if (tick) begin
      if (hist_q == {HW{synced}}) level_o <= synced;
      hist_q <= (hist_q << 1) | HW'(synced);
    end
  end
endmodule

// File: rtl/clkstop_park_seq.sv
// Decides the cycles at which stoppable pairs halt or resume and at which
// all pairs enter or leave power-down parking.
module clkstop_park_seq (
  input  logic clk,
  input  logic rst,
  input  logic phase,
  input  logic stop_act,
  input  logic pd_act,
  input  logic stop_tri,
  output logic halted_o,
  output logic pd_parked_o
);
  logic next_ph;
  logic stop_park_lvl;

  assign next_ph       = ~phase;
  assign stop_park_lvl = ~stop_tri;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_o    <= 1'b0;
      pd_parked_o <= 1'b0;
    end else begin
      // Halt or resume only where the running phase meets the park level.
      if (next_ph == stop_park_lvl) halted_o <= stop_act;
      // Power-down changes at the complement leg's falling transition.
      if (next_ph) pd_parked_o <= pd_act;
    end
  end
endmodule

// File: rtl/clkstop_pair_drive.sv
module clkstop_pair_drive
  import clkstop_pkg::*;
(
  input  logic phase,
  input  logic halted,
  input  logic pd_parked,
  input  logic stoppable,
  input  logic enable,
  input  logic stop_tri,
  input  logic pd_tri,
  output leg_t legs_o
);
  always_comb begin
    if (!enable)                 legs_o = '0;
    else if (pd_parked)          legs_o = park_legs(pd_tri);
    else if (halted && stoppable) legs_o = park_legs(stop_tri);
    else begin
      legs_o.p    = phase;
      legs_o.n    = ~phase;
      legs_o.p_oe = 1'b1;
      legs_o.n_oe = 1'b1;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_PAIRS    = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req_n_i,
  input  logic                 pd_req_n_i,
  input  logic [NUM_PAIRS-1:0] oe_pin_i,
  input  logic                 oe_pol_i,
  input  logic [NUM_PAIRS-1:0] cfg_en_i,
  input  logic [NUM_PAIRS-1:0] cfg_stoppable_i,
  input  logic                 cfg_stop_tri_i,
  input  logic                 cfg_pd_tri_i,
  output logic [NUM_PAIRS-1:0] out_p_o,
  output logic [NUM_PAIRS-1:0] out_n_o,
  output logic [NUM_PAIRS-1:0] out_p_oe_o,
  output logic [NUM_PAIRS-1:0] out_n_oe_o
);
  logic phase;
  logic pol_q;
  logic stop_lvl, pd_lvl;
  logic halted, pd_parked;

  // Free-running output phase; the complement rises when phase is 1 here.
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  // Polarity select follows the pin only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) pol_q <= oe_pol_i;
  end

  clkstop_req_qual #(
    .SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES), .IDLE_LVL(REQ_IDLE)
  ) u_stop_qual (
    .clk(clk), .rst(rst), .tick(phase), .req_async(stop_req_n_i), .level_o(stop_lvl)
  );

  clkstop_req_qual #(
    .SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES), .IDLE_LVL(REQ_IDLE)
  ) u_pd_qual (
    .clk(clk), .rst(rst), .tick(phase), .req_async(pd_req_n_i), .level_o(pd_lvl)
  );

  clkstop_park_seq u_seq (
    .clk(clk), .rst(rst), .phase(phase),
    .stop_act(~stop_lvl), .pd_act(~pd_lvl), .stop_tri(cfg_stop_tri_i),
    .halted_o(halted), .pd_parked_o(pd_parked)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic pair_en;
    leg_t legs;
    assign pair_en = cfg_en_i[g] & (oe_pin_i[g] ^ pol_q);

    clkstop_pair_drive u_drv (
      .phase(phase), .halted(halted), .pd_parked(pd_parked),
      .stoppable(cfg_stoppable_i[g]), .enable(pair_en),
      .stop_tri(cfg_stop_tri_i), .pd_tri(cfg_pd_tri_i), .legs_o(legs)
    );

    assign out_p_o[g]    = legs.p;
    assign out_n_o[g]    = legs.n;
    assign out_p_oe_o[g] = legs.p_oe;
    assign out_n_oe_o[g] = legs.n_oe;
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NUM_PAIRS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 phase,
  input logic                 stop_lvl,
  input logic                 pd_lvl,
  input logic                 pd_parked,
  input logic [NUM_PAIRS-1:0] cfg_en_i,
  input logic [NUM_PAIRS-1:0] out_p_o,
  input logic [NUM_PAIRS-1:0] out_n_o,
  input logic [NUM_PAIRS-1:0] out_p_oe_o,
  input logic [NUM_PAIRS-1:0] out_n_oe_o
);
  // R3: accepted request levels move only on qualification ticks.
  p_stop_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (stop_lvl != $past(stop_lvl)) |-> $past(phase));
  p_pd_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (pd_lvl != $past(pd_lvl)) |-> $past(phase));

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
    // R2: two driven legs are always complementary.
    p_legs_opposite_r2: assert property (@(posedge clk) disable iff (rst)
      (out_p_oe_o[g] && out_n_oe_o[g]) |-> (out_p_o[g] != out_n_o[g]));
    // R6: a driven true leg changes only to the free-running phase level.
    p_edge_aligned_r6: assert property (@(posedge clk) disable iff (rst)
      (out_p_oe_o[g] && $past(out_p_oe_o[g]) && (out_p_o[g] != $past(out_p_o[g])))
        |-> (out_p_o[g] == phase));
    // R10: a register-disabled pair drives nothing.
    p_reg_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !cfg_en_i[g] |-> !(out_p_o[g] || out_n_o[g] || out_p_oe_o[g] || out_n_oe_o[g]));
    // R9: under power-down park no pair toggles or drives its complement.
    p_pd_overrides_r9: assert property (@(posedge clk) disable iff (rst)
      pd_parked |-> (!out_p_oe_o[g] || (out_p_o[g] && !out_n_oe_o[g])));
  end
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .stop_lvl(stop_lvl), .pd_lvl(pd_lvl),
  .pd_parked(pd_parked), .cfg_en_i(cfg_en_i), .out_p_o(out_p_o), .out_n_o(out_n_o),
  .out_p_oe_o(out_p_oe_o), .out_n_oe_o(out_n_oe_o)
);

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1, pd_n = 1'b1;
  logic [NP-1:0] oe_pin = '1, cfg_en = '1, cfg_stp = '0;
  logic oe_pol = 1'b0, stop_tri = 1'b0, pd_tri = 1'b0;
  logic pol_ref = 1'b0;
  wire [NP-1:0] p, n, poe, noe;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkstop_ctrl #(.NUM_PAIRS(NP)) uut (
    .clk(clk), .rst(rst), .stop_req_n_i(stop_n), .pd_req_n_i(pd_n),
    .oe_pin_i(oe_pin), .oe_pol_i(oe_pol), .cfg_en_i(cfg_en),
    .cfg_stoppable_i(cfg_stp), .cfg_stop_tri_i(stop_tri), .cfg_pd_tri_i(pd_tri),
    .out_p_o(p), .out_n_o(n), .out_p_oe_o(poe), .out_n_oe_o(noe)
  );

  // {p,n,p_oe,n_oe} for a parked pair in the given mode (R5, R8).
  function automatic logic [3:0] park_exp(input logic tri_m);
    return tri_m ? 4'b0000 : 4'b1010;
  endfunction

  function automatic logic en_eff(input int i);
    return cfg_en[i] & (oe_pin[i] ^ pol_ref);
  endfunction

  function automatic logic [3:0] legs(input int i);
    return {p[i], n[i], poe[i], noe[i]};
  endfunction

  task automatic step();
    @(posedge clk); #(CLK_PERIOD/4);
  endtask

  task automatic chk_toggle(input int i, input int cyc, input string tag);
    logic prev;
    logic [3:0] a, e;
    bit bad = 0;
    checks++;
    step();
    prev = p[i];
    for (int k = 0; k < cyc; k++) begin
      step();
      a = legs(i);
      e = {~prev, prev, 2'b11};
      if (!bad && a != e) begin
        bad = 1;
        errors++;
        $display("FAIL %s pair %0d running: actual=%b expected=%b", tag, i, a, e);
      end
      prev = p[i];
    end
  endtask

  task automatic chk_park(input int i, input logic [3:0] e, input int cyc, input string tag);
    logic [3:0] a;
    bit bad = 0;
    checks++;
    for (int k = 0; k < cyc; k++) begin
      step();
      a = legs(i);
      if (!bad && a != e) begin
        bad = 1;
        errors++;
        $display("FAIL %s pair %0d parked: actual=%b expected=%b", tag, i, a, e);
      end
    end
  endtask

  task automatic chk_pair(input int i, input bit stop_on, input bit pd_on, input string tag);
    if (!en_eff(i))                  chk_park(i, 4'b0000, 4, tag);
    else if (pd_on)                  chk_park(i, park_exp(pd_tri), 4, tag);
    else if (stop_on && cfg_stp[i])  chk_park(i, park_exp(stop_tri), 4, tag);
    else                             chk_toggle(i, 4, tag);
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst = 1'b1; oe_pol = pol; pol_ref = pol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic apply(input bit stop_on, input bit pd_on);
    @(negedge clk);
    stop_n = ~stop_on; pd_n = ~pd_on;
    repeat (14) step();
  endtask

  task automatic release_all();
    @(negedge clk);
    stop_n = 1'b1; pd_n = 1'b1;
    repeat (16) step();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int first;
    bit apart;
    void'($urandom(32'd4242));

    // R1: reset state, phase low, all enabled pairs driven.
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    for (int i = 0; i < NP; i++) begin
      checks++;
      if (legs(i) != 4'b0111) begin
        errors++;
        $display("FAIL R1 pair %0d reset: actual=%b expected=0111", i, legs(i));
      end
    end
    do_reset(1'b0);
    for (int i = 0; i < NP; i++) chk_toggle(i, 6, "R2");

    // R4/R5: stop with mixed stoppable bits, both stop modes.
    @(negedge clk); cfg_stp = 4'b0101; stop_tri = 1'b0;
    apply(1, 0);
    for (int i = 0; i < NP; i++) chk_pair(i, 1, 0, cfg_stp[i] ? "R5" : "R4");
    release_all();
    @(negedge clk); stop_tri = 1'b1;
    repeat (4) step();
    apply(1, 0);
    for (int i = 0; i < NP; i++) chk_pair(i, 1, 0, cfg_stp[i] ? "R5" : "R4");
    release_all();

    // R3: one-cycle pulses on either request are ignored.
    @(negedge clk); stop_n = 1'b0;
    @(negedge clk); stop_n = 1'b1;
    chk_toggle(0, 16, "R3");
    @(negedge clk); pd_n = 1'b0;
    @(negedge clk); pd_n = 1'b1;
    chk_toggle(1, 16, "R3");

    // R6: stopped pairs resume together within the latency window.
    @(negedge clk); stop_tri = 1'b0;
    repeat (4) step();
    apply(1, 0);
    @(negedge clk); stop_n = 1'b1;
    first = 0; apart = 0;
    for (int k = 1; k <= 16; k++) begin
      step();
      if (first == 0 && p[0] != 1'b1) first = k;
      if (legs(0) != legs(2)) apart = 1;
    end
    checks++;
    if (first < 4 || first > 13) begin
      errors++;
      $display("FAIL R6 resume latency: actual=%0d expected=4..13", first);
    end
    checks++;
    if (apart) begin
      errors++;
      $display("FAIL R6 simultaneous resume: actual=apart expected=together");
    end
    repeat (8) step();

    // R7/R8: power-down parks all pairs in both modes.
    @(negedge clk); pd_tri = 1'b1;
    apply(0, 1);
    for (int i = 0; i < NP; i++) chk_pair(i, 0, 1, "R8");
    release_all();
    for (int i = 0; i < NP; i++) chk_toggle(i, 4, "R12");
    @(negedge clk); pd_tri = 1'b0;
    apply(0, 1);
    for (int i = 0; i < NP; i++) chk_pair(i, 0, 1, "R7");
    release_all();

    // R9: power-down beats stop.
    @(negedge clk); stop_tri = 1'b1;
    apply(1, 1);
    for (int i = 0; i < NP; i++) chk_pair(i, 1, 1, "R9");
    release_all();

    // R10: register disable and inactive pin.
    @(negedge clk); cfg_en = 4'b1101; oe_pin = 4'b1011;
    repeat (2) step();
    chk_park(1, 4'b0000, 4, "R10");
    chk_park(2, 4'b0000, 4, "R10");
    chk_toggle(0, 4, "R10");

    // R11: polarity captured at reset only.
    @(negedge clk); cfg_en = '1; oe_pin = '1; oe_pol = 1'b1;
    chk_toggle(3, 6, "R11");
    do_reset(1'b1);
    @(negedge clk); oe_pin = 4'b0011;
    repeat (2) step();
    chk_toggle(2, 4, "R11");
    chk_park(0, 4'b0000, 4, "R11");
    @(negedge clk); oe_pol = 1'b0;
    repeat (2) step();
    chk_park(1, 4'b0000, 4, "R11");

    // Random configurations and request mixes.
    for (int it = 0; it < 24; it++) begin
      int sc;
      @(negedge clk);
      cfg_en   = NP'($urandom);
      cfg_stp  = NP'($urandom);
      oe_pin   = NP'($urandom);
      stop_tri = 1'($urandom);
      pd_tri   = 1'($urandom);
      repeat (4) step();
      for (int i = 0; i < NP; i++) chk_pair(i, 0, 0, "R12");
      sc = int'($urandom % 4);
      apply(sc[0], sc[1]);
      for (int i = 0; i < NP; i++) chk_pair(i, sc[0], sc[1], "R9");
      release_all();
    end

    finish_run();
  end
endmodule